// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block recovers character frames from an asynchronous serial line and turns each one into a parallel byte in a receive buffer register. A 16x bit-rate enable pulse comes from outside, so several receivers or a transmitter can share one baud generator. The frame format is set at run time: five to eight data bits, least significant bit first, an optional parity bit with even or odd sense, then stop bits. Only the first stop bit is examined, so the stop length setting does not matter to this block. The serial input passes through a two-flop synchronizer before any sampling.

A state machine steps through the states IDLE, START, DATA, PARITY and STOP. IDLE moves to START when a sample at a tick is low and the sample at the previous tick was high. START moves back to IDLE if the line is high again eight ticks later. If the line is still low, START moves to DATA. DATA samples one bit every sixteen ticks and leaves after the last data bit, either to PARITY when parity is on or straight to STOP. PARITY samples one bit and moves to STOP. STOP samples the first stop bit, hands the finished frame to the buffer and returns to IDLE. The buffer logic then raises data-ready and updates the status flags. A one-cycle buffer-read strobe clears data-ready and overrun. The format inputs must stay stable while a frame is in progress.

Top module: `async_rx`

## Requirements
- R1: After reset, rx_data is 0 and data_ready, overrun_err, parity_err, framing_err and break_det are all 0.
- R2: A valid frame puts its data bits into rx_data, first received bit in bit 0, and sets data_ready.
- R3: word_sel picks the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Buffer bits above the word length read as 0.
- R4: With parity_on at 1, the bit after the data is a parity bit. parity_err is set when the count of ones over data and parity is odd while parity_even is 1, or even while parity_even is 0. With parity_on at 0, parity_err is 0 after each frame.
- R5: framing_err is set when the first stop bit is sampled low, and is cleared by a frame whose stop bit is high.
- R6: break_det is set, together with framing_err and an all-zero rx_data, when every sampled position from start through stop is low.
- R7: When a frame completes while data_ready is still 1 and no read is happening, overrun_err is set and rx_data holds the newer byte.
- R8: A one-cycle pulse on buf_rd clears data_ready and overrun_err.
- R9: A low pulse that is gone by the start-bit check, eight ticks after detection, yields no frame.
- R10: A new frame needs a high-to-low transition. A line held low after a break produces no further frames.
- R11: parity_err, framing_err and break_det describe the most recent frame and change only when a frame completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| rx_serial | input | 1 | Asynchronous serial input, idle high |
| word_sel | input | 2 | Word length select (0..3 gives 5..8 bits) |
| parity_on | input | 1 | Expect and check a parity bit |
| parity_even | input | 1 | 1 selects even parity, 0 selects odd |
| buf_rd | input | 1 | Buffer read strobe, clears data_ready and overrun_err |
| rx_data | output | 8 | Receive buffer |
| data_ready | output | 1 | Buffer holds an unread byte |
| overrun_err | output | 1 | A byte was overwritten before it was read |
| parity_err | output | 1 | Parity mismatch in the last frame |
| framing_err | output | 1 | First stop bit of the last frame was low |
| break_det | output | 1 | Last frame was all low, stop bit included |

## Verification
The assertions check on every cycle how the buffer interface behaves. data_ready and parity_err rise only after a completed frame, and parity_err only when parity is on. A read with no frame completing clears data_ready and overrun_err. overrun_err rises only while data_ready was set. rx_data and the error flags stay unchanged between frames. A break always comes with a framing error and zero data. Some behaviour only the directed scenarios can show, because it depends on what was driven on the line. This covers the bit order and values for each word length, parity sense, false-start rejection, and the need for an idle-high edge after a break.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_t;

    localparam int unsigned OVERSAMPLE = 16;
    localparam int unsigned MAX_WORD   = 8;

endpackage

// File: rtl/async_rx_sync.sv
module async_rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/async_rx_fsm.sv
module async_rx_fsm
    import async_rx_pkg::*;
#(
    parameter int unsigned OSR    = OVERSAMPLE,
    parameter int unsigned DATA_W = MAX_WORD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxs,
    input  logic [1:0]        word_sel,
    input  logic              parity_on,
    input  logic              parity_even,
    output logic              frame_done,
    output logic [DATA_W-1:0] frame_data,
    output logic              frame_perr,
    output logic              frame_ferr,
    output logic              frame_brk
);

    localparam int unsigned CW   = $clog2(OSR);
    localparam int unsigned IW   = $clog2(DATA_W);
    localparam int unsigned HALF = OSR / 2;
    localparam logic [CW-1:0] CNT_HALF = CW'(HALF - 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(OSR - 1);
    localparam logic [IW-1:0] IDX_BASE = IW'(DATA_W - 4);

    rx_state_t state, state_nx;

    logic [CW-1:0]     cnt;
    logic [IW-1:0]     bit_idx;
    logic [IW-1:0]     last_idx;
    logic [DATA_W-1:0] shreg;
    logic              par_acc;
    logic              all_low;
    logic              rx_prev;
    logic              start_edge;
    logic              half_pt;
    logic              sample_pt;

    assign last_idx   = IDX_BASE + IW'(word_sel);
    assign start_edge = tick && rx_prev && !rxs;
    assign half_pt    = tick && (cnt == CNT_HALF);
    assign sample_pt  = tick && (cnt == CNT_FULL);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start_edge) state_nx = ST_START;
            end
            ST_START: begin
                if (half_pt) state_nx = rxs ? ST_IDLE : ST_DATA;
            end
            ST_DATA: begin
                if (sample_pt && (bit_idx == last_idx))
                    state_nx = parity_on ? ST_PARITY : ST_STOP;
            end
            ST_PARITY: begin
                if (sample_pt) state_nx = ST_STOP;
            end
            ST_STOP: begin
                if (sample_pt) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            bit_idx    <= '0;
            shreg      <= '0;
            par_acc    <= 1'b0;
            all_low    <= 1'b1;
            rx_prev    <= 1'b1;
            frame_done <= 1'b0;
            frame_data <= '0;
            frame_perr <= 1'b0;
            frame_ferr <= 1'b0;
            frame_brk  <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (tick) rx_prev <= rxs;

            unique case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (start_edge) begin
                        bit_idx <= '0;
                        shreg   <= '0;
                        par_acc <= 1'b0;
                        all_low <= 1'b1;
                    end
                end
                ST_START: begin
                    if (half_pt)   cnt <= '0;
                    else if (tick) cnt <= cnt + 1'b1;
                end
                ST_DATA: begin
                    if (sample_pt) begin
                        cnt            <= '0;
                        shreg[bit_idx] <= rxs;
                        par_acc        <= par_acc ^ rxs;
                        all_low        <= all_low & ~rxs;
                        bit_idx        <= bit_idx + 1'b1;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PARITY: begin
                    if (sample_pt) begin
                        cnt     <= '0;
                        par_acc <= par_acc ^ rxs;
                        all_low <= all_low & ~rxs;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (sample_pt) begin
                        cnt        <= '0;
                        frame_done <= 1'b1;
                        frame_data <= shreg;
                        frame_perr <= parity_on & (par_acc ^ ~parity_even);
                        frame_ferr <= ~rxs;
                        frame_brk  <= all_low & ~rxs;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

endmodule

// File: rtl/async_rx_buffer.sv
module async_rx_buffer #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic [DATA_W-1:0] frame_data,
    input  logic              frame_perr,
    input  logic              frame_ferr,
    input  logic              frame_brk,
    input  logic              buf_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              data_ready,
    output logic              overrun_err,
    output logic              parity_err,
    output logic              framing_err,
    output logic              break_det
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data     <= '0;
            data_ready  <= 1'b0;
            overrun_err <= 1'b0;
            parity_err  <= 1'b0;
            framing_err <= 1'b0;
            break_det   <= 1'b0;
        end else if (frame_done) begin
            rx_data     <= frame_data;
            parity_err  <= frame_perr;
            framing_err <= frame_ferr;
            break_det   <= frame_brk;
            data_ready  <= 1'b1;
            overrun_err <= (overrun_err | data_ready) & ~buf_rd;
        end else if (buf_rd) begin
            data_ready  <= 1'b0;
            overrun_err <= 1'b0;
        end
    end

endmodule

// File: rtl/async_rx.sv
module async_rx
    import async_rx_pkg::*;
#(
    parameter int unsigned OSR       = OVERSAMPLE,
    parameter int unsigned DATA_W    = MAX_WORD,
    parameter int unsigned SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rx_serial,
    input  logic [1:0]        word_sel,
    input  logic              parity_on,
    input  logic              parity_even,
    input  logic              buf_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              data_ready,
    output logic              overrun_err,
    output logic              parity_err,
    output logic              framing_err,
    output logic              break_det
);

    logic              rx_sync;
    logic              frame_done;
    logic [DATA_W-1:0] frame_data;
    logic              frame_perr;
    logic              frame_ferr;
    logic              frame_brk;

    async_rx_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_serial),
        .dout  (rx_sync)
    );

    async_rx_fsm #(.OSR(OSR), .DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick16),
        .rxs         (rx_sync),
        .word_sel    (word_sel),
        .parity_on   (parity_on),
        .parity_even (parity_even),
        .frame_done  (frame_done),
        .frame_data  (frame_data),
        .frame_perr  (frame_perr),
        .frame_ferr  (frame_ferr),
        .frame_brk   (frame_brk)
    );

    async_rx_buffer #(.DATA_W(DATA_W)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_done  (frame_done),
        .frame_data  (frame_data),
        .frame_perr  (frame_perr),
        .frame_ferr  (frame_ferr),
        .frame_brk   (frame_brk),
        .buf_rd      (buf_rd),
        .rx_data     (rx_data),
        .data_ready  (data_ready),
        .overrun_err (overrun_err),
        .parity_err  (parity_err),
        .framing_err (framing_err),
        .break_det   (break_det)
    );

endmodule

// File: rtl/async_rx_checker.sv
module async_rx_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              buf_rd,
    input logic              parity_on,
    input logic              frame_done,
    input logic [DATA_W-1:0] rx_data,
    input logic              data_ready,
    input logic              overrun_err,
    input logic              parity_err,
    input logic              framing_err,
    input logic              break_det
);

    // R2: data_ready rises only one cycle after a completed frame
    a_r2_ready_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ready) |-> $past(frame_done));

    // R4: parity_err rises only after a frame received with parity on
    a_r4_parity_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(parity_err) |-> $past(frame_done && parity_on));

    // R6: break comes with a framing error and zero data
    a_r6_break_consistent: assert property (@(posedge clk) disable iff (!rst_n)
        break_det |-> (framing_err && (rx_data == '0)));

    // R7: overrun rises only while an unread byte was present
    a_r7_overrun_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_err) |-> $past(data_ready));

    // R8: a read with no frame completing clears ready and overrun
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd && !frame_done) |=> (!data_ready && !overrun_err));

    // R11: buffer and error flags hold between frames
    a_r11_hold_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> ($stable(rx_data) && $stable(parity_err)
                         && $stable(framing_err) && $stable(break_det)));

endmodule

bind async_rx async_rx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .buf_rd      (buf_rd),
    .parity_on   (parity_on),
    .frame_done  (frame_done),
    .rx_data     (rx_data),
    .data_ready  (data_ready),
    .overrun_err (overrun_err),
    .parity_err  (parity_err),
    .framing_err (framing_err),
    .break_det   (break_det)
);

// File: tb/tb_async_rx.sv
`timescale 1ns/1ps
module tb_async_rx;

    localparam int TICK_DIV = 4;
    localparam int BIT_CLKS = TICK_DIV * 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rx_serial = 1'b1;
    logic [1:0] word_sel = 2'd3;
    logic       parity_on = 1'b0;
    logic       parity_even = 1'b0;
    logic       buf_rd = 1'b0;
    logic [7:0] rx_data;
    logic       data_ready, overrun_err, parity_err, framing_err, break_det;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    int tdiv = 0;
    always @(posedge clk) begin
        tdiv   <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        tick16 <= (tdiv == TICK_DIV - 1);
    end

    async_rx dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_serial(rx_serial),
        .word_sel(word_sel), .parity_on(parity_on), .parity_even(parity_even),
        .buf_rd(buf_rd), .rx_data(rx_data), .data_ready(data_ready),
        .overrun_err(overrun_err), .parity_err(parity_err),
        .framing_err(framing_err), .break_det(break_det)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send_bit(logic v);
        rx_serial = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_frame(int nb, logic [7:0] d, bit pe, bit even,
                              bit flip_par, bit stop_v);
        bit p;
        word_sel    = 2'(nb - 5);
        parity_on   = pe;
        parity_even = even;
        p = 1'b0;
        for (int i = 0; i < nb; i++) p ^= d[i];
        if (!even) p = ~p;
        p ^= flip_par;
        send_bit(1'b0);
        for (int i = 0; i < nb; i++) send_bit(d[i]);
        if (pe) send_bit(p);
        send_bit(stop_v);
        send_bit(1'b1);
    endtask

    task automatic do_read();
        @(negedge clk) buf_rd = 1'b1;
        @(negedge clk) buf_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "rx_data", rx_data, 0);
        chk("R1", "data_ready", data_ready, 0);
        chk("R1", "flags", {overrun_err, parity_err, framing_err, break_det}, 0);
    endtask

    task automatic t_basic();
        send_frame(8, 8'hA5, 0, 0, 0, 1);
        chk("R2", "data_ready", data_ready, 1);
        chk("R2", "rx_data 8N1", rx_data, 8'hA5);
        chk("R5", "no framing", framing_err, 0);
        do_read();
        chk("R8", "ready cleared", data_ready, 0);
        send_frame(8, 8'h3C, 0, 0, 0, 1);
        chk("R2", "rx_data second", rx_data, 8'h3C);
        do_read();
    endtask

    task automatic t_lengths();
        send_frame(5, 8'hF5, 0, 0, 0, 1);
        chk("R3", "5-bit word", rx_data, 8'h15);
        do_read();
        send_frame(6, 8'hEA, 0, 0, 0, 1);
        chk("R3", "6-bit word", rx_data, 8'h2A);
        do_read();
        send_frame(7, 8'hFF, 0, 0, 0, 1);
        chk("R3", "7-bit word", rx_data, 8'h7F);
        do_read();
    endtask

    task automatic t_parity();
        send_frame(8, 8'h07, 1, 1, 0, 1);
        chk("R4", "even ok", parity_err, 0);
        chk("R4", "data with parity", rx_data, 8'h07);
        do_read();
        send_frame(8, 8'h07, 1, 1, 1, 1);
        chk("R4", "even bad", parity_err, 1);
        do_read();
        send_frame(7, 8'h55, 1, 0, 0, 1);
        chk("R4", "odd ok", parity_err, 0);
        do_read();
        send_frame(6, 8'h01, 1, 0, 1, 1);
        chk("R4", "odd bad", parity_err, 1);
        do_read();
        send_frame(8, 8'h81, 0, 0, 0, 1);
        chk("R4", "parity off", parity_err, 0);
        chk("R11", "flags per frame", framing_err, 0);
        do_read();
    endtask

    task automatic t_framing();
        send_frame(8, 8'h5A, 0, 0, 0, 0);
        chk("R5", "framing set", framing_err, 1);
        chk("R6", "no break", break_det, 0);
        chk("R5", "data kept", rx_data, 8'h5A);
        do_read();
        send_frame(8, 8'h11, 0, 0, 0, 1);
        chk("R5", "framing cleared", framing_err, 0);
        do_read();
    endtask

    task automatic t_break();
        word_sel = 2'd3; parity_on = 1'b0;
        rx_serial = 1'b0;
        repeat (12 * BIT_CLKS) @(negedge clk);
        chk("R6", "break", break_det, 1);
        chk("R6", "break framing", framing_err, 1);
        chk("R6", "break data", rx_data, 0);
        do_read();
        repeat (20 * BIT_CLKS) @(negedge clk);
        chk("R10", "no frame while low", data_ready, 0);
        rx_serial = 1'b1;
        repeat (2 * BIT_CLKS) @(negedge clk);
        send_frame(8, 8'hC3, 0, 0, 0, 1);
        chk("R10", "frame after idle", rx_data, 8'hC3);
        chk("R6", "break cleared", break_det, 0);
        do_read();
    endtask

    task automatic t_overrun();
        send_frame(8, 8'h12, 0, 0, 0, 1);
        chk("R7", "no overrun first", overrun_err, 0);
        send_frame(8, 8'h34, 0, 0, 0, 1);
        chk("R7", "overrun", overrun_err, 1);
        chk("R7", "newer byte", rx_data, 8'h34);
        do_read();
        chk("R8", "overrun cleared", overrun_err, 0);
        chk("R8", "ready cleared", data_ready, 0);
    endtask

    task automatic t_glitch();
        rx_serial = 1'b0;
        repeat (3 * TICK_DIV) @(negedge clk);
        rx_serial = 1'b1;
        repeat (20 * BIT_CLKS) @(negedge clk);
        chk("R9", "glitch rejected", data_ready, 0);
        send_frame(8, 8'h96, 0, 0, 0, 1);
        chk("R9", "frame after glitch", rx_data, 8'h96);
        do_read();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2 * BIT_CLKS) @(negedge clk);
        t_basic();
        t_lengths();
        t_parity();
        t_framing();
        t_overrun();
        t_glitch();
        t_break();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule